// File: doc/BRIEF.md
# External Interrupt Request Register Unit

This unit keeps the external-interrupt state of one processor. It holds a pending register and an enable mask, and it asserts a hard interrupt request whenever any pending bit is also enabled. Any bus agent, such as a system controller or another processor sending an interprocessor interrupt, posts an interrupt by writing a bit number to a bus-mapped posting word. That number names a position counted from the most significant end of the register. A timer alarm posts number 0 in the same way.

The processor side has two register writes. A clear write removes every pending bit where the written value has a one. A mask write replaces the enable mask. The active register width is 32 bits, or 64 bits when the wide-mode select is high in a build with the 64-bit variant enabled. A small arbiter combines a latched non-maskable request with the hard request and the processor's interrupt-enable bit. It presents one event at a time, either a transfer-of-control event or an external-interrupt event, and the core accepts it with a take strobe.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset the pending register and the mask are zero. `irq_hard` is 0 and `evt_valid` is 0.
- R2: In narrow mode, an accepted bus write of value D sets pending bit 31 - (D mod 32). Bit 0 is the least significant bit. The update is visible after the next rising clock edge.
- R3: With `wide_sel`=1 in a build with HAS_WIDE=1, an accepted bus write of value D sets pending bit 63 - (D mod 64).
- R4: Only accesses with `bus_size`=4 (a byte count) are accepted. A write of any other size leaves the pending register unchanged. A read of any other size returns 0.
- R5: A read with `bus_size`=4 and `bus_rd_en`=1 returns the whole pending register on `bus_rdata` in the same cycle.
- R6: A processor clear write of V gives pending <= pending & ~V. Bits where V is 0 are kept.
- R7: A processor mask write replaces the whole mask with the written value.
- R8: `irq_hard` is 1 exactly while (pending & mask) is nonzero. It follows each pending or mask update in the cycle after the write edge.
- R9: A `timer_alarm` pulse sets the most significant active bit: bit 31 in narrow mode, bit 63 in wide mode. A bus post in the same cycle is also applied.
- R10: When a post and a clear hit the same bit in the same cycle, that bit ends up set.
- R11: A `nmi_raise` pulse latches a non-maskable request. While it is latched, `evt_valid`=1 and `evt_toc`=1, whatever the state of `psw_ie` or `irq_hard`. An `evt_take` while it is latched clears it, unless a new raise arrives in the same cycle.
- R12: With no non-maskable request latched, `evt_valid` is 1 only when `psw_ie`=1 and `irq_hard`=1, and `evt_toc` is then 0 (external interrupt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Bus write to the posting word |
| bus_rd_en | input | 1 | Bus read of the posting word |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Posted interrupt number |
| bus_rdata | output | WIDE_W | Pending register read value |
| cpu_clr_we | input | 1 | Processor write-one-to-clear strobe |
| cpu_clr_data | input | WIDE_W | Bits to clear |
| cpu_mask_we | input | 1 | Processor mask load strobe |
| cpu_mask_data | input | WIDE_W | New mask value |
| timer_alarm | input | 1 | Alarm pulse, posts number 0 |
| wide_sel | input | 1 | Selects 64-bit register width |
| nmi_raise | input | 1 | Non-maskable request pulse |
| psw_ie | input | 1 | Processor interrupt-enable bit |
| evt_take | input | 1 | Core accepts the presented event |
| irq_hard | output | 1 | Hard interrupt request |
| evt_valid | output | 1 | An event is presented |
| evt_toc | output | 1 | 1 = transfer of control, 0 = external interrupt |

## Verification
The bench builds the unit with its defaults: NARROW_W=32, WIDE_W=64 and HAS_WIDE=1. Both widths can therefore be exercised in one run by toggling `wide_sel`. This covers the bit-number folding at both moduli and the timer posting to bit 31 or bit 63. It also covers posts whose numbers wrap past the register width. Because the width is selected at run time, a bit posted in wide mode stays readable after a switch back to narrow mode.

// File: rtl/eir_pkg.sv
package eir_pkg;
  localparam int unsigned BUS_DATA_W = 32;
  localparam logic [2:0] BUS_WORD_BYTES = 3'd4;

  typedef enum logic {
    EVT_EXT = 1'b0,
    EVT_TOC = 1'b1
  } evt_kind_t;

  // true when an access has the single legal size of the posting word
  function automatic logic word_access(input logic [2:0] nbytes);
    return nbytes == BUS_WORD_BYTES;
  endfunction
endpackage

// File: rtl/eir_post_decode.sv
module eir_post_decode
  import eir_pkg::*;
#(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 64,
  parameter bit          HAS_WIDE = 1'b1
) (
  input  logic                  bus_wr_en,
  input  logic [2:0]            bus_size,
  input  logic [BUS_DATA_W-1:0] bus_wdata,
  input  logic                  timer_alarm,
  input  logic                  wide_sel,
  output logic                  use_wide,
  output logic                  post_accept,
  output logic [WIDE_W-1:0]     set_vec
);
  localparam int unsigned IDX_W  = $clog2(WIDE_W);
  localparam int unsigned NIDX_W = $clog2(NARROW_W);

  logic [IDX_W-1:0] post_slot;
  logic [IDX_W-1:0] top_slot;
  logic             unused_data_hi;

  generate
    if (HAS_WIDE) begin : g_wide_capable
      assign use_wide = wide_sel;
    end else begin : g_narrow_only
      logic unused_wide_sel;
      assign unused_wide_sel = wide_sel;
      assign use_wide        = 1'b0;
    end
  endgenerate

  // Number counted from the top end: inverting the low bits folds
  // (W-1) - (n mod W) for a power-of-two width.
  function automatic logic [IDX_W-1:0] slot_of(input logic [IDX_W-1:0] num,
                                               input logic wide);
    logic [IDX_W-1:0] r;
    if (wide) r = ~num;
    else      r = {{(IDX_W-NIDX_W){1'b0}}, ~num[NIDX_W-1:0]};
    return r;
  endfunction

  function automatic logic [WIDE_W-1:0] onehot(input logic [IDX_W-1:0] i);
    return {{(WIDE_W-1){1'b0}}, 1'b1} << i;
  endfunction

  assign unused_data_hi = ^bus_wdata[BUS_DATA_W-1:IDX_W];
  assign post_accept    = bus_wr_en && word_access(bus_size);
  assign post_slot      = slot_of(bus_wdata[IDX_W-1:0], use_wide);
  assign top_slot       = use_wide ? IDX_W'(WIDE_W-1) : IDX_W'(NARROW_W-1);

  assign set_vec = (post_accept ? onehot(post_slot) : '0)
                 | (timer_alarm ? onehot(top_slot)  : '0);
endmodule

// File: rtl/eir_state.sv
module eir_state #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic         mask_we,
  input  logic [W-1:0] mask_data,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] mask_q,
  output logic         irq_hard
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] pend_d;

  // posts are applied after the clear so a colliding post survives
  function automatic logic [W-1:0] next_pending(input logic [W-1:0] cur,
                                                input logic [W-1:0] clr,
                                                input logic [W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  assign clr_vec = clr_we ? clr_data : '0;
  assign pend_d  = next_pending(pend_q, clr_vec, set_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (mask_we) mask_q <= mask_data;
    end
  end

  assign irq_hard = |(pend_q & mask_q);
endmodule

// File: rtl/eir_event_arb.sv
module eir_event_arb
  import eir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_raise,
  input  logic evt_take,
  input  logic psw_ie,
  input  logic irq_hard,
  output logic evt_valid,
  output logic evt_toc,
  output logic nmi_pend_q,
  output logic toc_taken
);
  evt_kind_t kind;
  logic      ext_ready;

  assign toc_taken = evt_take && nmi_pend_q;
  assign ext_ready = psw_ie && irq_hard;

  always_ff @(posedge clk) begin
    if (!rst_n)         nmi_pend_q <= 1'b0;
    else if (nmi_raise) nmi_pend_q <= 1'b1;
    else if (toc_taken) nmi_pend_q <= 1'b0;
  end

  always_comb begin
    kind = nmi_pend_q ? EVT_TOC : EVT_EXT;
  end

  assign evt_valid = nmi_pend_q || ext_ready;
  assign evt_toc   = (kind == EVT_TOC);
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import eir_pkg::*;
#(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 64,
  parameter bit          HAS_WIDE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [2:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [WIDE_W-1:0] bus_rdata,
  input  logic              cpu_clr_we,
  input  logic [WIDE_W-1:0] cpu_clr_data,
  input  logic              cpu_mask_we,
  input  logic [WIDE_W-1:0] cpu_mask_data,
  input  logic              timer_alarm,
  input  logic              wide_sel,
  input  logic              nmi_raise,
  input  logic              psw_ie,
  input  logic              evt_take,
  output logic              irq_hard,
  output logic              evt_valid,
  output logic              evt_toc
);
  logic              use_wide;
  logic              post_accept;
  logic [WIDE_W-1:0] set_vec;
  logic [WIDE_W-1:0] pend_q;
  logic [WIDE_W-1:0] mask_q;
  logic              nmi_pend_q;
  logic              toc_taken;

  eir_post_decode #(
    .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .HAS_WIDE(HAS_WIDE)
  ) u_decode (
    .bus_wr_en  (bus_wr_en),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .timer_alarm(timer_alarm),
    .wide_sel   (wide_sel),
    .use_wide   (use_wide),
    .post_accept(post_accept),
    .set_vec    (set_vec)
  );

  eir_state #(.W(WIDE_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_we   (cpu_clr_we),
    .clr_data (cpu_clr_data),
    .mask_we  (cpu_mask_we),
    .mask_data(cpu_mask_data),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .irq_hard (irq_hard)
  );

  eir_event_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_raise (nmi_raise),
    .evt_take  (evt_take),
    .psw_ie    (psw_ie),
    .irq_hard  (irq_hard),
    .evt_valid (evt_valid),
    .evt_toc   (evt_toc),
    .nmi_pend_q(nmi_pend_q),
    .toc_taken (toc_taken)
  );

  assign bus_rdata = (bus_rd_en && word_access(bus_size)) ? pend_q : '0;
endmodule

// File: rtl/eir_checker.sv
module eir_checker
  import eir_pkg::*;
#(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [2:0]        bus_size,
  input logic              timer_alarm,
  input logic              cpu_clr_we,
  input logic [WIDE_W-1:0] cpu_clr_data,
  input logic              cpu_mask_we,
  input logic [WIDE_W-1:0] cpu_mask_data,
  input logic              nmi_raise,
  input logic              psw_ie,
  input logic              evt_take,
  input logic              irq_hard,
  input logic              evt_valid,
  input logic              evt_toc,
  input logic              use_wide,
  input logic [WIDE_W-1:0] set_vec,
  input logic [WIDE_W-1:0] pend_q,
  input logic [WIDE_W-1:0] mask_q,
  input logic              nmi_pend_q
);
  a_r2_narrow_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !use_wide |-> set_vec[WIDE_W-1:NARROW_W] == '0);

  a_r4_bad_size_no_post: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !word_access(bus_size) && !timer_alarm && !cpu_clr_we)
      |=> $stable(pend_q));

  a_r6_cleared_bits_gone: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clr_we |=> (pend_q & $past(cpu_clr_data & ~set_vec)) == '0);

  a_r7_mask_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mask_we |=> mask_q == $past(cpu_mask_data));

  a_r8_irq_rises_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hard) |-> $past(set_vec != '0 || cpu_mask_we));

  a_r10_post_survives: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec != '0 |=> (pend_q & $past(set_vec)) == $past(set_vec));

  a_r11_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend_q |-> (evt_valid && evt_toc));

  a_r11_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_take && nmi_pend_q && !nmi_raise) |=> !nmi_pend_q);

  a_r12_ext_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_toc) |-> (psw_ie && irq_hard));
endmodule

bind ext_irq_unit eir_checker #(
  .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr_en    (bus_wr_en),
  .bus_size     (bus_size),
  .timer_alarm  (timer_alarm),
  .cpu_clr_we   (cpu_clr_we),
  .cpu_clr_data (cpu_clr_data),
  .cpu_mask_we  (cpu_mask_we),
  .cpu_mask_data(cpu_mask_data),
  .nmi_raise    (nmi_raise),
  .psw_ie       (psw_ie),
  .evt_take     (evt_take),
  .irq_hard     (irq_hard),
  .evt_valid    (evt_valid),
  .evt_toc      (evt_toc),
  .use_wide     (use_wide),
  .set_vec      (set_vec),
  .pend_q       (pend_q),
  .mask_q       (mask_q),
  .nmi_pend_q   (nmi_pend_q)
);

// File: tb/ext_irq_unit_test.sv
module ext_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en, bus_rd_en;
  logic [2:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        cpu_clr_we, cpu_mask_we;
  logic [63:0] cpu_clr_data, cpu_mask_data;
  logic        timer_alarm, wide_sel, nmi_raise, psw_ie, evt_take;
  logic        irq_hard, evt_valid, evt_toc;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_pend;

  always #2ns clk = ~clk;

  ext_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_clr_we(cpu_clr_we), .cpu_clr_data(cpu_clr_data),
    .cpu_mask_we(cpu_mask_we), .cpu_mask_data(cpu_mask_data),
    .timer_alarm(timer_alarm), .wide_sel(wide_sel), .nmi_raise(nmi_raise),
    .psw_ie(psw_ie), .evt_take(evt_take), .irq_hard(irq_hard),
    .evt_valid(evt_valid), .evt_toc(evt_toc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int bit_for(input int d, input bit wide);
    return wide ? 63 - (d % 64) : 31 - (d % 32);
  endfunction

  task automatic read_pend(input logic [2:0] sz, output logic [63:0] v);
    bus_rd_en = 1'b1; bus_size = sz;
    #1ns v = bus_rdata;
    bus_rd_en = 1'b0; bus_size = 3'd0;
  endtask

  task automatic check_pend(input string req);
    logic [63:0] v;
    read_pend(3'd4, v);
    check(req, v, exp_pend);
  endtask

  task automatic bus_post(input int d, input logic [2:0] sz);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_size = 3'd0; bus_wdata = '0;
  endtask

  task automatic cpu_clear(input logic [63:0] v);
    @(negedge clk);
    cpu_clr_we = 1'b1; cpu_clr_data = v;
    @(negedge clk);
    cpu_clr_we = 1'b0; cpu_clr_data = '0;
    exp_pend = exp_pend & ~v;
  endtask

  task automatic cpu_mask(input logic [63:0] v);
    @(negedge clk);
    cpu_mask_we = 1'b1; cpu_mask_data = v;
    @(negedge clk);
    cpu_mask_we = 1'b0; cpu_mask_data = '0;
  endtask

  task automatic t_reset;
    check_pend("R1 pending after reset");
    check("R1 irq after reset", {63'd0, irq_hard}, 64'd0);
    check("R1 evt_valid after reset", {63'd0, evt_valid}, 64'd0);
    cpu_mask(64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 mask starts zero: no irq with empty pending", {63'd0, irq_hard}, 64'd0);
    cpu_mask(64'd0);
  endtask

  task automatic t_narrow;
    int nums[3] = '{0, 5, 40};
    wide_sel = 1'b0;
    foreach (nums[k]) begin
      bus_post(nums[k], 3'd4);
      exp_pend[bit_for(nums[k], 1'b0)] = 1'b1;
      check_pend("R2 narrow post / R5 read");
    end
    cpu_clear(64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_wide;
    wide_sel = 1'b1;
    bus_post(0, 3'd4);  exp_pend[bit_for(0, 1'b1)] = 1'b1;
    check_pend("R3 wide post of 0");
    bus_post(70, 3'd4); exp_pend[bit_for(70, 1'b1)] = 1'b1;
    check_pend("R3 wide post of 70");
    wide_sel = 1'b0;
    check_pend("R5 wide bits still read in narrow mode");
  endtask

  task automatic t_size;
    logic [63:0] v;
    bus_post(1, 3'd2);
    check_pend("R4 2-byte write ignored");
    bus_post(2, 3'd1);
    check_pend("R4 1-byte write ignored");
    read_pend(3'd2, v);
    check("R4 2-byte read returns 0", v, 64'd0);
  endtask

  task automatic t_clear;
    cpu_clear(64'h8000_0000_0000_0000);
    check_pend("R6 clear single bit keeps others");
    cpu_clear(64'h0000_0000_0000_0001);
    check_pend("R6 clear of zero bit no effect");
    cpu_clear(64'hFFFF_FFFF_FFFF_FFFF);
    check_pend("R6 clear all");
  endtask

  task automatic t_mask_irq;
    bus_post(4, 3'd4); exp_pend[27] = 1'b1;
    check("R8 pending but masked -> no irq", {63'd0, irq_hard}, 64'd0);
    cpu_mask(64'h0000_0000_0000_0010);
    check("R7 unrelated mask bit -> no irq", {63'd0, irq_hard}, 64'd0);
    cpu_mask(64'h0000_0000_0800_0000);
    check("R7 R8 mask load enables irq", {63'd0, irq_hard}, 64'd1);
    cpu_clear(64'h0000_0000_0800_0000);
    check("R8 irq drops after clear", {63'd0, irq_hard}, 64'd0);
    bus_post(4, 3'd4); exp_pend[27] = 1'b1;
    check("R8 irq back after repost", {63'd0, irq_hard}, 64'd1);
    cpu_mask(64'd0);
    check("R7 mask replaced by zero", {63'd0, irq_hard}, 64'd0);
    cpu_clear(64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_timer;
    wide_sel = 1'b0;
    @(negedge clk); timer_alarm = 1'b1;
    @(negedge clk); timer_alarm = 1'b0;
    exp_pend[31] = 1'b1;
    check_pend("R9 narrow timer sets bit 31");
    wide_sel = 1'b1;
    @(negedge clk);
    timer_alarm = 1'b1; bus_wr_en = 1'b1; bus_size = 3'd4; bus_wdata = 32'd9;
    @(negedge clk);
    timer_alarm = 1'b0; bus_wr_en = 1'b0; bus_size = 3'd0; bus_wdata = '0;
    exp_pend[63] = 1'b1; exp_pend[bit_for(9, 1'b1)] = 1'b1;
    check_pend("R9 wide timer plus bus post");
    wide_sel = 1'b0;
    cpu_clear(64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_collision;
    bus_post(12, 3'd4); exp_pend[19] = 1'b1;
    @(negedge clk);
    cpu_clr_we = 1'b1; cpu_clr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    bus_wr_en = 1'b1; bus_size = 3'd4; bus_wdata = 32'd3;
    @(negedge clk);
    cpu_clr_we = 1'b0; cpu_clr_data = '0;
    bus_wr_en = 1'b0; bus_size = 3'd0; bus_wdata = '0;
    exp_pend = 64'd0; exp_pend[28] = 1'b1;
    check_pend("R10 post wins over same-cycle clear");
    cpu_clear(64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_events;
    psw_ie = 1'b0;
    bus_post(1, 3'd4); exp_pend[30] = 1'b1;
    cpu_mask(64'h0000_0000_4000_0000);
    check("R12 irq set but ie off -> no event", {63'd0, evt_valid}, 64'd0);
    psw_ie = 1'b1; #1ns;
    check("R12 ext event valid", {62'd0, evt_valid, evt_toc}, 64'd2);
    psw_ie = 1'b0;
    @(negedge clk); nmi_raise = 1'b1;
    @(negedge clk); nmi_raise = 1'b0;
    check("R11 nmi event with ie off", {62'd0, evt_valid, evt_toc}, 64'd3);
    psw_ie = 1'b1; #1ns;
    check("R11 nmi over ext", {62'd0, evt_valid, evt_toc}, 64'd3);
    @(negedge clk); evt_take = 1'b1; nmi_raise = 1'b1;
    @(negedge clk); evt_take = 1'b0; nmi_raise = 1'b0;
    check("R11 new raise beats take", {62'd0, evt_valid, evt_toc}, 64'd3);
    @(negedge clk); evt_take = 1'b1;
    @(negedge clk); evt_take = 1'b0;
    check("R11 take clears nmi, ext remains", {62'd0, evt_valid, evt_toc}, 64'd2);
    psw_ie = 1'b0; #1ns;
    check("R12 ext withdrawn when ie off", {63'd0, evt_valid}, 64'd0);
  endtask

  initial begin
    #(4ns * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_size = 3'd0;
    bus_wdata = '0; cpu_clr_we = 1'b0; cpu_clr_data = '0; cpu_mask_we = 1'b0;
    cpu_mask_data = '0; timer_alarm = 1'b0; wide_sel = 1'b0; nmi_raise = 1'b0;
    psw_ie = 1'b0; evt_take = 1'b0; exp_pend = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_wide();
    t_size();
    t_clear();
    t_mask_irq();
    t_timer();
    t_collision();
    t_events();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule